// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the control path of one DMA channel. Software loads a configuration word, an item count and two base addresses: one for the peripheral side and one for the memory side. When the channel is enabled, has items left and has a reason to move data, it raises a want signal toward the channel arbiter. A reason to move data is either a peripheral request or memory-to-memory mode. On a grant it presents one transfer to the bus master: a source address, a destination address and the access size for each side. It holds that transfer until the bus answers with an acknowledge or an error.

After each acknowledged transfer the sequencer decrements the remaining count. If increment is enabled for a side, it advances that side's address. It raises one-cycle event pulses when the count passes its half mark, when it reaches zero, and when the bus reports an error. In circular mode the count and both addresses return to their programmed values when the count runs out, so the channel runs on without software help.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the configuration word, count, both current addresses, bus_valid, all event pulses and irq are zero.
- R2: Writes to the count and to either base address take effect only while configuration bit 0 (enable) is 0 and no transfer is outstanding. Otherwise they are ignored. A count write sets both the remaining count and the reload value.
- R3: xfer_want is high only when all three hold: the channel is enabled, the count is non-zero, and either periph_req or configuration bit 14 (memory-to-memory) is high. A transfer starts the cycle after xfer_want and xfer_grant are both high. bus_valid and the bus fields then stay unchanged until bus_ack or bus_err.
- R4: Configuration bit 4 selects the direction. With 0 the source is the peripheral address with the peripheral size (bits 9:8) and the destination is the memory address with the memory size (bits 11:10). With 1 the two sides are swapped.
- R5: Size code 0 means 8 bits, 1 means 16 bits and 2 means 32 bits. A presented address has bit 0 cleared for 16-bit accesses and bits 1:0 cleared for 32-bit accesses.
- R6: After an acknowledged transfer, the peripheral address advances by 1, 2 or 4 bytes according to its own size if bit 6 is set. The memory address does the same if bit 7 is set.
- R7: Each acknowledged transfer lowers the remaining count by one.
- R8: The transfer that brings the count to zero raises ev_done. Outside circular mode the count then stays at zero and no further transfer is requested.
- R9: With configuration bit 5 (circular) set, the transfer that empties the count reloads the programmed count and restores both addresses to their base values.
- R10: ev_half pulses after the transfer whose new count equals the programmed count divided by two, rounded down. For a programmed count of 1 it coincides with ev_done.
- R11: A bus error raises ev_err and clears the enable bit, and leaves the count and addresses unchanged. The error wins when bus_ack and bus_err arrive together.
- R12: irq is high in the cycle of an event pulse whose enable is set: bit 1 for ev_done, bit 2 for ev_half, bit 3 for ev_err.
- R13: chan_prio shows configuration bits 13:12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 15 | Configuration write value |
| cfg_q | output | 15 | Current configuration word |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | CW | Count write value |
| cnt_q | output | CW | Remaining item count |
| par_we | input | 1 | Peripheral base address write strobe |
| mar_we | input | 1 | Memory base address write strobe |
| addr_wdata | input | AW | Address write value |
| par_q | output | AW | Current peripheral address |
| mar_q | output | AW | Current memory address |
| periph_req | input | 1 | Peripheral asks for service |
| xfer_want | output | 1 | Channel ready to transfer, to arbiter |
| xfer_grant | input | 1 | Grant from arbiter |
| chan_prio | output | 2 | Channel priority level |
| bus_valid | output | 1 | Transfer presented to the bus master |
| bus_src_addr | output | AW | Aligned source address |
| bus_src_size | output | 2 | Source size code |
| bus_dst_addr | output | AW | Aligned destination address |
| bus_dst_size | output | 2 | Destination size code |
| bus_ack | input | 1 | Transfer finished without error |
| bus_err | input | 1 | Transfer ended in error |
| ev_half | output | 1 | Half-way event pulse |
| ev_done | output | 1 | Count-exhausted event pulse |
| ev_err | output | 1 | Bus error event pulse |
| irq | output | 1 | Masked OR of the event pulses |

## Verification
Two event functions can fall on the same acknowledge. A programmed count of 1 makes the half-way event and the completion event fire in the same cycle, and the bench drives exactly that case and expects both pulses together. In circular mode the completion and the reload of the count and both addresses also land on one edge; the scoreboard predicts the wrapped addresses of the next transfers. A bus response carrying acknowledge and error together is also provoked, and it must be judged as an error only, with the count unchanged and no done or half pulse.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int CFG_W       = 15;
  localparam int CFG_EN      = 0;
  localparam int CFG_DONE_IE = 1;
  localparam int CFG_HALF_IE = 2;
  localparam int CFG_ERR_IE  = 3;
  localparam int CFG_DIR     = 4;
  localparam int CFG_CIRC    = 5;
  localparam int CFG_PINC    = 6;
  localparam int CFG_MINC    = 7;
  localparam int CFG_PSZ     = 8;   // two bits
  localparam int CFG_MSZ     = 10;  // two bits
  localparam int CFG_PRIO    = 12;  // two bits
  localparam int CFG_M2M     = 14;

  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} seq_state_e;

  // Byte step of one item of the given size code (code 3 treated as word)
  function automatic logic [2:0] size_step(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // Low address bits forced to zero for the given size code
  function automatic logic [1:0] size_lowmask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 2'b00;
      2'd1:    return 2'b01;
      default: return 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/dma_seq_addr.sv
module dma_seq_addr
  import dma_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wdata,
  input  logic [1:0]    size,
  input  logic          inc,
  input  logic          adv,
  input  logic          rewind,
  output logic [AW-1:0] cur_q,
  output logic [AW-1:0] bus_addr
);
  logic [AW-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (wr_en) begin
      base_q <= wdata;
      cur_q  <= wdata;
    end else if (rewind) begin
      cur_q  <= base_q;
    end else if (adv && inc) begin
      cur_q  <= cur_q + AW'(size_step(size));
    end
  end

  assign bus_addr = {cur_q[AW-1:2], cur_q[1:0] & ~size_lowmask(size)};
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          circ,
  input  logic          m2m,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_wdata,
  input  logic          periph_req,
  input  logic          grant,
  input  logic          bus_ack,
  input  logic          bus_err,
  output logic [CW-1:0] cnt_q,
  output logic          want,
  output logic          bus_valid,
  output logic          xfer_ok,
  output logic          xfer_fail,
  output logic          wrap,
  output logic          ev_half,
  output logic          ev_done,
  output logic          ev_err
);
  localparam logic [CW-1:0] ONE = CW'(1);

  function automatic logic [CW-1:0] half_mark(input logic [CW-1:0] total);
    return total >> 1;
  endfunction

  seq_state_e    st_q;
  logic [CW-1:0] reload_q;
  logic [CW-1:0] cnt_dec;
  logic          last;
  logic          half_hit;
  logic          cnt_load;
  logic          start;

  assign bus_valid = (st_q == ST_BUSY);
  assign want      = (st_q == ST_IDLE) && en && (cnt_q != '0) && (periph_req || m2m);
  assign start     = want && grant;
  assign xfer_fail = bus_valid && bus_err;
  assign xfer_ok   = bus_valid && bus_ack && !bus_err;
  assign cnt_dec   = cnt_q - ONE;
  assign last      = (cnt_q == ONE);
  assign wrap      = xfer_ok && last && circ;
  assign half_hit  = xfer_ok && (cnt_dec == half_mark(reload_q));
  assign cnt_load  = cnt_we && !en && !bus_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      reload_q <= '0;
      ev_half  <= 1'b0;
      ev_done  <= 1'b0;
      ev_err   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) st_q <= ST_BUSY;
        default: if (bus_ack || bus_err) st_q <= ST_IDLE;
      endcase
      if (cnt_load) begin
        cnt_q    <= cnt_wdata;
        reload_q <= cnt_wdata;
      end else if (xfer_ok) begin
        cnt_q    <= wrap ? reload_q : cnt_dec;
      end
      ev_half <= half_hit;
      ev_done <= xfer_ok && last;
      ev_err  <= xfer_fail;
    end
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_q,
  input  logic             cnt_we,
  input  logic [CW-1:0]    cnt_wdata,
  output logic [CW-1:0]    cnt_q,
  input  logic             par_we,
  input  logic             mar_we,
  input  logic [AW-1:0]    addr_wdata,
  output logic [AW-1:0]    par_q,
  output logic [AW-1:0]    mar_q,
  input  logic             periph_req,
  output logic             xfer_want,
  input  logic             xfer_grant,
  output logic [1:0]       chan_prio,
  output logic             bus_valid,
  output logic [AW-1:0]    bus_src_addr,
  output logic [1:0]       bus_src_size,
  output logic [AW-1:0]    bus_dst_addr,
  output logic [1:0]       bus_dst_size,
  input  logic             bus_ack,
  input  logic             bus_err,
  output logic             ev_half,
  output logic             ev_done,
  output logic             ev_err,
  output logic             irq
);
  localparam int NSIDE = 2;  // 0: peripheral, 1: memory

  logic             xfer_ok;
  logic             xfer_fail;
  logic             wrap;
  logic             cfg_en;
  logic             addr_open;
  logic [NSIDE-1:0] side_we;
  logic [NSIDE-1:0] side_inc;
  logic [1:0]       side_sz  [NSIDE];
  logic [AW-1:0]    side_cur [NSIDE];
  logic [AW-1:0]    side_bus [NSIDE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      if (cfg_we)    cfg_q         <= cfg_wdata;
      if (xfer_fail) cfg_q[CFG_EN] <= 1'b0;
    end
  end

  assign cfg_en      = cfg_q[CFG_EN];
  assign chan_prio   = cfg_q[CFG_PRIO +: 2];
  assign addr_open   = !cfg_en && !bus_valid;
  assign side_we     = {mar_we && addr_open, par_we && addr_open};
  assign side_inc    = {cfg_q[CFG_MINC], cfg_q[CFG_PINC]};
  assign side_sz[0]  = cfg_q[CFG_PSZ +: 2];
  assign side_sz[1]  = cfg_q[CFG_MSZ +: 2];

  dma_seq_ctrl #(.CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (cfg_en),
    .circ       (cfg_q[CFG_CIRC]),
    .m2m        (cfg_q[CFG_M2M]),
    .cnt_we     (cnt_we),
    .cnt_wdata  (cnt_wdata),
    .periph_req (periph_req),
    .grant      (xfer_grant),
    .bus_ack    (bus_ack),
    .bus_err    (bus_err),
    .cnt_q      (cnt_q),
    .want       (xfer_want),
    .bus_valid  (bus_valid),
    .xfer_ok    (xfer_ok),
    .xfer_fail  (xfer_fail),
    .wrap       (wrap),
    .ev_half    (ev_half),
    .ev_done    (ev_done),
    .ev_err     (ev_err)
  );

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_seq_addr #(.AW(AW)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (side_we[g]),
      .wdata    (addr_wdata),
      .size     (side_sz[g]),
      .inc      (side_inc[g]),
      .adv      (xfer_ok && !wrap),
      .rewind   (wrap),
      .cur_q    (side_cur[g]),
      .bus_addr (side_bus[g])
    );
  end

  assign par_q = side_cur[0];
  assign mar_q = side_cur[1];

  always_comb begin
    if (cfg_q[CFG_DIR]) begin
      bus_src_addr = side_bus[1];
      bus_src_size = side_sz[1];
      bus_dst_addr = side_bus[0];
      bus_dst_size = side_sz[0];
    end else begin
      bus_src_addr = side_bus[0];
      bus_src_size = side_sz[0];
      bus_dst_addr = side_bus[1];
      bus_dst_size = side_sz[1];
    end
  end

  assign irq = (ev_done && cfg_q[CFG_DONE_IE]) ||
               (ev_half && cfg_q[CFG_HALF_IE]) ||
               (ev_err  && cfg_q[CFG_ERR_IE]);
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [14:0]   cfg_q,
  input logic [CW-1:0] cnt_q,
  input logic          bus_valid,
  input logic          bus_ack,
  input logic          bus_err,
  input logic [AW-1:0] bus_src_addr,
  input logic [1:0]    bus_src_size,
  input logic [AW-1:0] bus_dst_addr,
  input logic [1:0]    bus_dst_size,
  input logic          xfer_ok,
  input logic          xfer_fail,
  input logic          ev_half,
  input logic          ev_done,
  input logic          ev_err,
  input logic          irq
);
  assert_cnt_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[0] && !xfer_ok |=> $stable(cnt_q));

  assert_no_empty_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> cnt_q != '0);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ack && !bus_err |=>
      bus_valid && $stable(bus_src_addr) && $stable(bus_dst_addr));

  assert_src_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_src_size == 2'd0 || !bus_src_addr[0]) &&
                  (!bus_src_size[1] || bus_src_addr[1:0] == 2'b00));

  assert_dst_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_dst_size == 2'd0 || !bus_dst_addr[0]) &&
                  (!bus_dst_size[1] || bus_dst_addr[1:0] == 2'b00));

  assert_decrement_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ok && cnt_q > CW'(1) |=> cnt_q == $past(cnt_q) - CW'(1));

  assert_done_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done && !cfg_q[5] |-> cnt_q == '0);

  assert_err_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_fail |=> ev_err && !cfg_q[0] && $stable(cnt_q));

  assert_err_alone_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |-> !ev_done && !ev_half);

  assert_irq_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ev_done || ev_half || ev_err);
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_q        (cfg_q),
  .cnt_q        (cnt_q),
  .bus_valid    (bus_valid),
  .bus_ack      (bus_ack),
  .bus_err      (bus_err),
  .bus_src_addr (bus_src_addr),
  .bus_src_size (bus_src_size),
  .bus_dst_addr (bus_dst_addr),
  .bus_dst_size (bus_dst_size),
  .xfer_ok      (xfer_ok),
  .xfer_fail    (xfer_fail),
  .ev_half      (ev_half),
  .ev_done      (ev_done),
  .ev_err       (ev_err),
  .irq          (irq)
);

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cnt_we, par_we, mar_we;
  logic [14:0] cfg_wdata, cfg_q;
  logic [15:0] cnt_wdata, cnt_q;
  logic [31:0] addr_wdata, par_q, mar_q;
  logic        periph_req, xfer_want, xfer_grant;
  logic [1:0]  chan_prio;
  logic        bus_valid, bus_ack, bus_err;
  logic [31:0] bus_src_addr, bus_dst_addr;
  logic [1:0]  bus_src_size, bus_dst_size;
  logic        ev_half, ev_done, ev_err, irq;

  int checks = 0;
  int fails  = 0;
  logic [15:0] fin_cnt;
  logic [31:0] fin_p, fin_m;

  typedef struct {
    logic [31:0] src, dst;
    logic [1:0]  ssz, dsz;
    bit          err, half, done, irq;
    logic [15:0] cnt;
  } item_t;
  item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_seq uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  function automatic logic [31:0] al(input logic [31:0] a, input logic [1:0] sz);
    return a - (a % nbytes(sz));
  endfunction

  task automatic wr_cfg(input logic [14:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic wr_cnt(input logic [15:0] v);
    @(negedge clk); cnt_we = 1; cnt_wdata = v;
    @(negedge clk); cnt_we = 0;
  endtask
  task automatic wr_addr(input bit mem, input logic [31:0] v);
    @(negedge clk); addr_wdata = v; if (mem) mar_we = 1; else par_we = 1;
    @(negedge clk); mar_we = 0; par_we = 0;
  endtask

  // Driver: predicts every transfer and pushes it to the scoreboard, then runs the channel
  task automatic run(input logic [14:0] cfg, input logic [15:0] n, input logic [31:0] p, m,
                     input int items, input int err_at);
    logic [15:0] c = n;
    logic [31:0] cp = p, cm = m;
    logic [1:0]  psz = cfg[9:8], msz = cfg[11:10];
    for (int k = 0; k < items; k++) begin
      item_t it;
      logic [15:0] nc;
      if (c == 0) break;
      it.ssz = cfg[4] ? msz : psz;
      it.dsz = cfg[4] ? psz : msz;
      it.src = cfg[4] ? al(cm, msz) : al(cp, psz);
      it.dst = cfg[4] ? al(cp, psz) : al(cm, msz);
      if (k == err_at) begin
        it.err = 1; it.half = 0; it.done = 0; it.irq = cfg[3]; it.cnt = c;
        exp_q.push_back(it);
        break;
      end
      nc = c - 16'd1;
      it.err  = 0;
      it.half = (nc == n / 2);
      it.done = (nc == 0);
      it.irq  = (it.done && cfg[1]) || (it.half && cfg[2]);
      if (it.done && cfg[5]) begin
        c = n; cp = p; cm = m;
      end else begin
        c = nc;
        if (cfg[6]) cp = cp + nbytes(psz);
        if (cfg[7]) cm = cm + nbytes(msz);
      end
      it.cnt = c;
      exp_q.push_back(it);
    end
    fin_cnt = c; fin_p = cp; fin_m = cm;
    wr_cnt(n); wr_addr(0, p); wr_addr(1, m); wr_cfg(cfg);
    chk(chan_prio == cfg[13:12], "R13 priority", {30'd0, chan_prio}, {30'd0, cfg[13:12]});
    xfer_grant = 1;
    wait (exp_q.size() == 0 && xfer_grant == 0);
    repeat (4) @(negedge clk);
    chk(cnt_q == fin_cnt, "R8 R9 final count", {16'd0, cnt_q}, {16'd0, fin_cnt});
    chk(par_q == fin_p, "R6 R9 final peripheral address", par_q, fin_p);
    chk(mar_q == fin_m, "R6 R9 final memory address", mar_q, fin_m);
    wr_cfg(cfg & ~15'h1);
  endtask

  // Monitor: pops the expected item whenever a transfer appears and judges its effects
  initial begin
    bus_ack = 0; bus_err = 0;
    forever begin
      @(negedge clk);
      if (rst_n && bus_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R3 unexpected transfer", 32'd1, 32'd0);
          xfer_grant = 0;
          bus_ack = 1;
          @(negedge clk);
          bus_ack = 0;
        end else begin
          item_t it;
          it = exp_q.pop_front();
          chk(bus_src_addr == it.src, "R4 R5 source address", bus_src_addr, it.src);
          chk(bus_dst_addr == it.dst, "R4 R5 destination address", bus_dst_addr, it.dst);
          chk({bus_src_size, bus_dst_size} == {it.ssz, it.dsz}, "R4 sizes",
              {28'd0, bus_src_size, bus_dst_size}, {28'd0, it.ssz, it.dsz});
          if (exp_q.size() == 0) xfer_grant = 0;
          bus_ack = 1;
          bus_err = it.err;
          @(negedge clk);
          bus_ack = 0; bus_err = 0;
          chk(cnt_q == it.cnt, "R7 R9 R11 count after transfer", {16'd0, cnt_q}, {16'd0, it.cnt});
          chk(ev_half == it.half, "R10 half event", {31'd0, ev_half}, {31'd0, it.half});
          chk(ev_done == it.done, "R8 done event", {31'd0, ev_done}, {31'd0, it.done});
          chk(ev_err == it.err, "R11 error event", {31'd0, ev_err}, {31'd0, it.err});
          chk(irq == it.irq, "R12 irq", {31'd0, irq}, {31'd0, it.irq});
          if (it.err) chk(cfg_q[0] == 1'b0, "R11 enable cleared", {31'd0, cfg_q[0]}, 32'd0);
        end
      end
    end
  end

  task automatic finish_up;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] held;
    rst_n = 0; cfg_we = 0; cnt_we = 0; par_we = 0; mar_we = 0;
    cfg_wdata = 0; cnt_wdata = 0; addr_wdata = 0; periph_req = 0; xfer_grant = 0;
    repeat (3) @(negedge clk);
    chk(cfg_q == 0 && cnt_q == 0, "R1 reset registers", {1'b0, cfg_q, cnt_q}, 32'd0);
    chk(par_q == 0 && mar_q == 0, "R1 reset addresses", par_q | mar_q, 32'd0);
    chk({bus_valid, ev_half, ev_done, ev_err, irq} == 0, "R1 reset outputs",
        {27'd0, bus_valid, ev_half, ev_done, ev_err, irq}, 32'd0);
    rst_n = 1;
    periph_req = 1;

    // peripheral to memory, byte peripheral fixed, word memory incrementing
    run(15'h2883, 16'd4, 32'h4000_0003, 32'h2000_0002, 4, -1);
    // memory to peripheral, halfwords both sides, circular, memory-to-memory without a request
    periph_req = 0;
    run(15'h75F5, 16'd3, 32'h1000_0011, 32'h2000_0101, 5, -1);
    periph_req = 1;
    // single item: half and done in the same cycle
    run(15'h0247, 16'd1, 32'h1000_0006, 32'h3000_0000, 1, -1);
    // bus error on the second item, ack and error together
    run(15'h0089, 16'd5, 32'h5000_0000, 32'h6000_0000, 5, 1);

    // zero count: nothing is served; count and address writes ignored while enabled
    wr_cnt(16'd0);
    wr_cfg(15'h0001);
    xfer_grant = 1;
    repeat (8) @(negedge clk);
    chk(xfer_want == 0 && bus_valid == 0, "R3 zero count serves nothing",
        {30'd0, xfer_want, bus_valid}, 32'd0);
    wr_cnt(16'd9);
    chk(cnt_q == 0, "R2 count write while enabled", {16'd0, cnt_q}, 32'd0);
    held = par_q;
    wr_addr(0, 32'hDEAD_0000);
    chk(par_q == held, "R2 address write while enabled", par_q, held);
    xfer_grant = 0;
    wr_cfg(15'h0000);

    // no peripheral request and no memory-to-memory mode
    wr_cnt(16'd2);
    periph_req = 0;
    wr_cfg(15'h0001);
    xfer_grant = 1;
    repeat (8) @(negedge clk);
    chk(xfer_want == 0, "R3 no request no want", {31'd0, xfer_want}, 32'd0);
    chk(cnt_q == 16'd2, "R3 count untouched", {16'd0, cnt_q}, 32'd2);
    xfer_grant = 0;
    periph_req = 1;
    @(negedge clk);
    chk(xfer_want == 1, "R3 request raises want", {31'd0, xfer_want}, 32'd1);
    periph_req = 0;
    wr_cfg(15'h0000);
    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule